// File: doc/BRIEF.md
# Four-Wire Serial Host Slave

This block is the byte-level slave end of a full-duplex four-wire serial control link. An external host drives a serial clock, a data line into the block and an active-low select. The block answers on a shared open-drain return line, which it can only pull low. While the select is low, every rising serial-clock edge captures one incoming bit and every falling edge advances the outgoing bit. Both directions run most significant bit first. Command decoding and register storage sit in a neighbouring block.

All serial pins are asynchronous to the block's system clock. They are resynchronised and edge-detected internally, so the system clock must run several times faster than the serial clock. The serial clock idles low. Received bytes leave on a valid-only stream: rx_valid_o is a one-cycle strobe. There is no ready, because the host cannot be stalled, and the consumer must take each byte in the cycle it is strobed. Response bytes enter on a valid/ready pair. tx_ready_o pulses for one cycle whenever the block loads its transmit shifter, and the word on tx_data_i is taken in that cycle. If tx_valid_i is low at that moment, the block loads an all-ones byte, which leaves the line released for the whole byte.

Top module: `hostlink_serial_slave`

## Requirements
- R1: The link is full duplex. While selected, each serial-clock period captures one bit from host_din_i and also advances one bit on the return line.
- R2: Both directions are most significant bit first. The first captured bit ends up in bit 7 of a full received byte, and bit 7 of the response word is the first bit sent.
- R3: Incoming data is sampled on rising serial-clock edges. The outgoing bit changes only on falling serial-clock edges, except for the first bit of a transfer.
- R4: The MSB of the first response byte appears on the return line at the falling edge of host_sel_ni, before any serial-clock edge. After the eighth rising edge of a byte, rx_valid_o pulses for one cycle with rx_bits_o = 8. The next response byte's MSB appears at the following falling serial-clock edge.
- R5: When host_sel_ni rises after 1 to 7 captured bits, rx_valid_o pulses once with rx_bits_o equal to the bit count. rx_data_o then holds the bits right-aligned: the last bit is in bit 0 and the unused upper bits are zero. When host_sel_ni rises after a whole number of bytes, no extra strobe is issued.
- R6: host_pull_low_o = 1 means the line is pulled low (bit value 0). host_pull_low_o = 0 means the line is released (bit value 1, high impedance). The line is released during reset and whenever the block is not selected.
- R7: tx_ready_o pulses for one cycle at each transmit load: once at the select falling edge, and once at the falling edge that follows each completed byte. If tx_valid_i is low at a load, the byte sent is 8'hFF.
- R8: Serial-clock and data activity while host_sel_ni is high produces no rx_valid_o strobe, no tx_ready_o pulse and no pull on the line.
- R9: After reset, rx_valid_o, tx_ready_o and host_pull_low_o are 0, rx_data_o is 0 and rx_bits_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, oversamples the serial pins |
| rst_ni | input | 1 | Active-low reset |
| host_clk_i | input | 1 | Serial clock from the host, idles low |
| host_sel_ni | input | 1 | Active-low select from the host |
| host_din_i | input | 1 | Serial data from the host |
| host_pull_low_o | output | 1 | Open-drain enable: 1 pulls the return line low |
| rx_valid_o | output | 1 | One-cycle strobe for a received byte |
| rx_data_o | output | 8 | Received byte, right-aligned when partial |
| rx_bits_o | output | 4 | Number of valid bits in rx_data_o (1 to 8) |
| tx_data_i | input | 8 | Next response byte |
| tx_valid_i | input | 1 | tx_data_i holds a real response |
| tx_ready_o | output | 1 | One-cycle pulse when the response byte is loaded |

## Verification
The bench checks the line state before every rising serial-clock edge. This catches a design that presents the MSB late, on the first clock instead of at select: the first bit would read back as the reset contents. It also catches a design that shifts on the wrong edge, which would offset the whole byte by one bit. Partial transfers of one and three bits catch a design that left-aligns the bits or forgets to strobe on the select rising edge. Multi-byte transfers count the load pulses, so a design that reloads too early or twice would show a wrong tx_ready_o count or a corrupted second byte. Clocks toggled while deselected would produce stray strobes in a design that does not gate on select.

// File: rtl/hss_pkg.sv
package hss_pkg;
  // Index of each host pin inside the synchroniser vector
  localparam int PinClk   = 0;
  localparam int PinSel   = 1;
  localparam int PinDin   = 2;
  localparam int PinCount = 3;
endpackage

// File: rtl/hss_sync.sv
module hss_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  for (genvar g = 0; g < WIDTH; g++) begin : g_chain
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= {STAGES{RST_VAL[g]}};
      else        chain_q <= {chain_q[STAGES-2:0], async_i[g]};
    end
    assign level_o[g] = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= level_o;
  end

  assign rise_o = level_o & ~prev_q;
  assign fall_o = ~level_o & prev_q;
endmodule

// File: rtl/hss_rx_path.sv
module hss_rx_path #(
  parameter int BYTE_W = 8,
  localparam int BITS_W = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              sck_rise,
  input  logic              sel_fall,
  input  logic              sel_rise,
  input  logic              din,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic [BITS_W-1:0] rx_bits_o
);
  logic [BYTE_W-1:0] shreg_q;
  logic [BITS_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q    <= '0;
      cnt_q      <= '0;
      rx_valid_o <= 1'b0;
      rx_data_o  <= '0;
      rx_bits_o  <= '0;
    end else begin
      rx_valid_o <= 1'b0;
      if (sel_fall) begin
        shreg_q <= '0;
        cnt_q   <= '0;
      end else if (active && sck_rise) begin
        if (cnt_q == BITS_W'(BYTE_W - 1)) begin
          rx_data_o  <= {shreg_q[BYTE_W-2:0], din};
          rx_bits_o  <= BITS_W'(BYTE_W);
          rx_valid_o <= 1'b1;
          shreg_q    <= '0;
          cnt_q      <= '0;
        end else begin
          shreg_q <= {shreg_q[BYTE_W-2:0], din};
          cnt_q   <= cnt_q + 1'b1;
        end
      end else if (sel_rise && cnt_q != '0) begin
        // shifting toward the MSB leaves a partial byte right-aligned
        rx_data_o  <= shreg_q;
        rx_bits_o  <= cnt_q;
        rx_valid_o <= 1'b1;
        cnt_q      <= '0;
      end
    end
  end

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |=> !rx_valid_o);
  assert_bits_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> (rx_bits_o != '0 && rx_bits_o <= BITS_W'(BYTE_W)));
  assert_clock_strobe_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid_o && $past(sck_rise)) |-> rx_bits_o == BITS_W'(BYTE_W));
endmodule

// File: rtl/hss_tx_path.sv
module hss_tx_path #(
  parameter int BYTE_W = 8,
  localparam int BITS_W = $clog2(BYTE_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_fall,
  input  logic              sel_rise,
  input  logic              sck_rise,
  input  logic              sck_fall,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic              pull_low_o
);
  logic [BYTE_W-1:0] shreg_q;
  logic [BITS_W-1:0] rises_q;
  logic              active_q;
  logic              pending_q;
  logic [BYTE_W-1:0] load_val;

  assign load_val   = tx_valid_i ? tx_data_i : '1;
  assign tx_ready_o = sel_fall | (active_q & sck_fall & pending_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q   <= '1;
      rises_q   <= '0;
      active_q  <= 1'b0;
      pending_q <= 1'b0;
    end else if (sel_fall) begin
      active_q  <= 1'b1;
      shreg_q   <= load_val;
      rises_q   <= '0;
      pending_q <= 1'b0;
    end else if (sel_rise) begin
      active_q  <= 1'b0;
      pending_q <= 1'b0;
    end else if (active_q) begin
      if (sck_rise) begin
        if (rises_q == BITS_W'(BYTE_W - 1)) begin
          rises_q   <= '0;
          pending_q <= 1'b1;
        end else begin
          rises_q <= rises_q + 1'b1;
        end
      end
      if (sck_fall) begin
        if (pending_q) begin
          shreg_q   <= load_val;
          pending_q <= 1'b0;
        end else begin
          shreg_q <= {shreg_q[BYTE_W-2:0], 1'b1};
        end
      end
    end
  end

  assign pull_low_o = active_q & ~shreg_q[BYTE_W-1];

  assert_ready_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready_o |=> !tx_ready_o);
  assert_bit_steady_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && sck_rise && !sel_fall && !sel_rise) |=> $stable(pull_low_o));
endmodule

// File: rtl/hostlink_serial_slave.sv
module hostlink_serial_slave #(
  parameter int BYTE_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int BITS_W = $clog2(BYTE_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_clk_i,
  input  logic              host_sel_ni,
  input  logic              host_din_i,
  output logic              host_pull_low_o,
  output logic              rx_valid_o,
  output logic [BYTE_W-1:0] rx_data_o,
  output logic [BITS_W-1:0] rx_bits_o,
  input  logic [BYTE_W-1:0] tx_data_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o
);
  import hss_pkg::*;

  localparam logic [PinCount-1:0] PinIdle = PinCount'(1) << PinSel;

  logic [PinCount-1:0] pins, lvl, rise, fall;

  always_comb begin
    pins         = '0;
    pins[PinClk] = host_clk_i;
    pins[PinSel] = host_sel_ni;
    pins[PinDin] = host_din_i;
  end

  hss_sync #(.WIDTH(PinCount), .STAGES(SYNC_STAGES), .RST_VAL(PinIdle)) i_sync (
    .clk(clk_i), .rst_n(rst_ni), .async_i(pins),
    .level_o(lvl), .rise_o(rise), .fall_o(fall));

  hss_rx_path #(.BYTE_W(BYTE_W)) i_rx (
    .clk(clk_i), .rst_n(rst_ni), .active(!lvl[PinSel]),
    .sck_rise(rise[PinClk]), .sel_fall(fall[PinSel]), .sel_rise(rise[PinSel]),
    .din(lvl[PinDin]), .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o),
    .rx_bits_o(rx_bits_o));

  hss_tx_path #(.BYTE_W(BYTE_W)) i_tx (
    .clk(clk_i), .rst_n(rst_ni), .sel_fall(fall[PinSel]), .sel_rise(rise[PinSel]),
    .sck_rise(rise[PinClk]), .sck_fall(fall[PinClk]),
    .tx_data_i(tx_data_i), .tx_valid_i(tx_valid_i), .tx_ready_o(tx_ready_o),
    .pull_low_o(host_pull_low_o));

  assert_released_unselected_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl[PinSel] && $past(lvl[PinSel])) |-> !host_pull_low_o);
  assert_no_ready_unselected_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl[PinSel] && !rise[PinSel]) |-> !tx_ready_o);
endmodule

// File: tb/test_hostlink_serial_slave.sv
module test_hostlink_serial_slave;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host_clk = 1'b0, host_sel_n = 1'b1, host_din = 1'b0;
  logic       pull_low, rx_valid, tx_valid = 1'b0, tx_ready;
  logic [7:0] rx_data, tx_data = 8'h00;
  logic [3:0] rx_bits;

  int checks = 0, fails = 0, ready_cnt = 0;
  logic [11:0] rxq [$];
  logic [7:0] in_b [0:3];
  logic [7:0] out_b [0:3];

  always #4 clk = ~clk;

  hostlink_serial_slave i_hostlink_serial_slave (
    .clk_i(clk), .rst_ni(rst_n), .host_clk_i(host_clk), .host_sel_ni(host_sel_n),
    .host_din_i(host_din), .host_pull_low_o(pull_low), .rx_valid_o(rx_valid),
    .rx_data_o(rx_data), .rx_bits_o(rx_bits), .tx_data_i(tx_data),
    .tx_valid_i(tx_valid), .tx_ready_o(tx_ready));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pop the expected received item on each strobe
  always @(negedge clk) begin
    if (rst_n && tx_ready) ready_cnt++;
    if (rst_n && rx_valid) begin
      if (rxq.size() == 0) begin
        chk(1'b0, "R8 unexpected strobe", int'(rx_data), 0);
      end else begin
        logic [11:0] e;
        e = rxq.pop_front();
        chk(rx_data == e[7:0], e[11:8] == 4'd8 ? "R4 rx data" : "R5 rx data",
            int'(rx_data), int'(e[7:0]));
        chk(rx_bits == e[11:8], e[11:8] == 4'd8 ? "R4 rx bits" : "R5 rx bits",
            int'(rx_bits), int'(e[11:8]));
      end
    end
  end

  // Driver: nb bytes, the last one carrying last_bits bits
  task automatic xfer(input int nb, input int last_bits, input bit vld);
    int exp_ready;
    ready_cnt = 0;
    tx_data  = out_b[0];
    tx_valid = vld;
    wclk(2);
    host_sel_n = 1'b0;
    wclk(6);
    for (int b = 0; b < nb; b++) begin
      int nbits;
      logic [7:0] mask;
      nbits = (b == nb - 1) ? last_bits : 8;
      mask  = 8'((9'd1 << nbits) - 9'd1);
      rxq.push_back({4'(nbits), in_b[b] & mask});
      for (int i = 0; i < nbits; i++) begin
        logic exp_bit;
        exp_bit = vld ? out_b[b][7-i] : 1'b1;
        // R1 R2 R3: line value before the capturing edge, MSB first
        chk(!pull_low == exp_bit, (i == 0) ? "R4 first bit" : "R3 line bit",
            int'(!pull_low), int'(exp_bit));
        host_din = in_b[b][nbits-1-i];
        wclk(6);
        host_clk = 1'b1;
        wclk(6);
        if (i == 7 && b + 1 < nb) tx_data = out_b[b+1];
        host_clk = 1'b0;
        wclk(6);
      end
    end
    host_sel_n = 1'b1;
    wclk(10);
    chk(!pull_low, "R6 released after deselect", int'(pull_low), 0);
    exp_ready = nb + ((last_bits == 8) ? 1 : 0);
    chk(ready_cnt == exp_ready, "R7 load pulses", ready_cnt, exp_ready);
    chk(rxq.size() == 0, "R1 all bytes received", rxq.size(), 0);
  endtask

  initial begin
    wclk(3);
    chk(!pull_low, "R6 released in reset", int'(pull_low), 0);
    rst_n = 1'b1;
    wclk(2);
    chk(!rx_valid && !tx_ready && !pull_low, "R9 reset outputs",
        {rx_valid, tx_ready, pull_low}, 0);
    chk(rx_data == 8'h00 && rx_bits == 4'd0, "R9 reset data", {rx_data, rx_bits}, 0);

    in_b[0] = 8'hA5; out_b[0] = 8'h3C;
    xfer(1, 8, 1'b1);

    in_b[0] = 8'h81; in_b[1] = 8'h7E; in_b[2] = 8'h0F;
    out_b[0] = 8'hC3; out_b[1] = 8'h5A; out_b[2] = 8'h01;
    xfer(3, 8, 1'b1);

    // R5: partial three-bit tail after a full byte
    in_b[0] = 8'h96; in_b[1] = 8'h05; out_b[0] = 8'h70; out_b[1] = 8'h9F;
    xfer(2, 3, 1'b1);

    // R5: single bit transfer
    in_b[0] = 8'h01; out_b[0] = 8'h00;
    xfer(1, 1, 1'b1);

    // R7: no response offered, all ones on the line
    in_b[0] = 8'h3E; out_b[0] = 8'h00;
    xfer(1, 8, 1'b0);

    // R8: clock and data activity while deselected
    ready_cnt = 0;
    tx_valid = 1'b1; tx_data = 8'h00;
    for (int k = 0; k < 10; k++) begin
      host_din = k[0];
      wclk(6); host_clk = 1'b1;
      chk(!pull_low, "R8 line untouched", int'(pull_low), 0);
      wclk(6); host_clk = 1'b0;
    end
    wclk(8);
    chk(ready_cnt == 0, "R8 no load pulse", ready_cnt, 0);
    chk(rxq.size() == 0, "R8 queue empty", rxq.size(), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule